// File: doc/BRIEF.md
# Adaptive Partition-Point Tuner

This block steers the boundary between the two regions of a 64-slot split translation buffer. One region holds mappings that are costly to refetch. The other holds mappings that are cheap to refetch. The buffer reports each translation miss with a class code. The tuner turns each miss into an estimate of its handling cost in cycles and adds that estimate to a saturating per-window sum. A window ends after a fixed number of classified misses. At that point the tuner compares the window's sum with the sum from the window before it.

A change is significant when the new sum differs from the old one by more than a programmable right-shifted fraction of the old sum. After a significant rise, the tuner reverses its search direction and takes one step. After a significant fall, it takes another step in the same direction. When the change is small, it holds its position. The first window after reset always tries one step upward. Steps that would leave the configured range are suppressed.

A separate saturating counter tallies first-level misses, so software does not need to count them.

Top module: `partition_tuner`

## Requirements
- R1: Class codes and their weights in cycles are: 0 user first-level = 20, 1 kernel first-level = 294, 2 second-level = 407, 3 third-level = 286, 4 other = 405. A miss with code 5, 6 or 7 is ignored: it adds no cost, does not advance the window, and does not touch the first-level counter.
- R2: A window closes on the WIN_MISSES-th counted miss. `updateStrobe` is high for exactly the one cycle that follows the clock edge on which that miss is sampled, and low at every other time.
- R3: The first window closed after reset moves the point one slot up, subject to R7.
- R4: When the closing window's cost is greater than prev + (prev >> cfgShift), the search direction reverses and the point steps once in the new direction.
- R5: When cost + (prev >> cfgShift) is less than prev, the point steps once in the unchanged direction.
- R6: In every other case the point and the direction both stay as they are.
- R7: The point stays within [max(cfgMin,1), min(cfgMax,63)]. A step that would leave that range is suppressed, and any direction change from R4 still takes effect.
- R8: The window cost saturates at 2^COST_W-1 and restarts from zero in every new window.
- R9: `upperSlots` always equals 64 minus `partPoint`.
- R10: `firstLevelCount` counts misses with code 0 or 1 and holds at its maximum value.
- R11: While reset is asserted, `partPoint` is INIT_POINT, `updateStrobe` is 0 and `firstLevelCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| missValid | input | 1 | A miss is reported this cycle |
| missClass | input | 3 | Class code of the reported miss |
| cfgMin | input | PT_W | Lowest permitted partition point (a value below 1 is treated as 1) |
| cfgMax | input | PT_W | Highest permitted partition point (a value above 63 is treated as 63) |
| cfgShift | input | SH_W | Right shift applied to the previous cost to form the significance threshold |
| partPoint | output | PT_W | Number of slots in the lower region |
| upperSlots | output | PT_W+1 | Number of slots in the upper region |
| updateStrobe | output | 1 | One-cycle pulse when a window is evaluated |
| firstLevelCount | output | CNT_W | Saturating count of first-level misses |

## Verification
On every cycle, the assertions check four things. The strobe is a single-cycle pulse. The point stays between 1 and 63. The point changes only together with the strobe and by at most one slot. The first-level counter never moves backwards and never jumps by more than one.

The bench alone can show the cost-driven choices: the first upward step, reversal after a rise, continuation after a fall, holding on a small change, suppression at the range limits and cost saturation. It does so by comparing every decision with an arithmetic model, across sweeps of mixed class patterns and threshold shifts.

// File: rtl/pptune_pkg.sv
package pptune_pkg;

  localparam int unsigned CLS_W = 3;
  localparam int unsigned WT_W  = 9;

  localparam logic [WT_W-1:0] WT_USER_L1 = 9'd20;
  localparam logic [WT_W-1:0] WT_KERN_L1 = 9'd294;
  localparam logic [WT_W-1:0] WT_L2      = 9'd407;
  localparam logic [WT_W-1:0] WT_L3      = 9'd286;
  localparam logic [WT_W-1:0] WT_OTHER   = 9'd405;

  typedef struct packed {
    logic closeWin;
    logic stepUp;
    logic stepDn;
  } tuneCtl_t;

  function automatic logic classKnown(input logic [CLS_W-1:0] cls);
    return cls <= 3'd4;
  endfunction

  function automatic logic [WT_W-1:0] classWeight(input logic [CLS_W-1:0] cls);
    logic [WT_W-1:0] w;
    case (cls)
      3'd0:    w = WT_USER_L1;
      3'd1:    w = WT_KERN_L1;
      3'd2:    w = WT_L2;
      3'd3:    w = WT_L3;
      3'd4:    w = WT_OTHER;
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pptune_datapath.sv
module pptune_datapath
  import pptune_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 64,
  parameter int unsigned WIN_MISSES = 256,
  parameter int unsigned COST_W     = 20,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned SH_W       = 4,
  parameter int unsigned INIT_POINT = 8,
  localparam int unsigned PT_W      = $clog2(NUM_SLOTS),
  localparam int unsigned WC_W      = $clog2(WIN_MISSES)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             missValid,
  input  logic [CLS_W-1:0] missClass,
  input  logic [PT_W-1:0]  cfgMin,
  input  logic [PT_W-1:0]  cfgMax,
  input  logic [SH_W-1:0]  cfgShift,
  input  tuneCtl_t         ctl,
  output logic             winDone,
  output logic             costUp,
  output logic             costDown,
  output logic             canUp,
  output logic             canDn,
  output logic [PT_W-1:0]  partPoint,
  output logic [CNT_W-1:0] firstLevelCount
);

  localparam logic [COST_W-1:0] COST_MAX = {COST_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [WC_W-1:0]   WC_LAST  = WC_W'(WIN_MISSES - 1);
  localparam logic [PT_W-1:0]   PT_TOP   = PT_W'(NUM_SLOTS - 1);
  localparam logic [PT_W-1:0]   PT_BOT   = PT_W'(1);

  logic [COST_W-1:0] winCost;
  logic [COST_W-1:0] prevCost;
  logic [COST_W-1:0] curCost;
  logic [COST_W:0]   sumWide;
  logic [COST_W:0]   thrWide;
  logic [WC_W-1:0]   missCnt;
  logic              counted;
  logic              firstLevel;
  logic [PT_W-1:0]   loBound;
  logic [PT_W-1:0]   hiBound;

  assign counted    = missValid && classKnown(missClass);
  assign firstLevel = missValid && (missClass == 3'd0 || missClass == 3'd1);
  assign winDone    = counted && (missCnt == WC_LAST);

  // Saturating add of the class weight into the running window sum.
  assign sumWide = {1'b0, winCost} + (COST_W+1)'(classWeight(missClass));
  assign curCost = sumWide[COST_W] ? COST_MAX : sumWide[COST_W-1:0];

  // Significance threshold and the two comparisons against it.
  assign thrWide  = (COST_W+1)'(prevCost >> cfgShift);
  assign costUp   = {1'b0, curCost} > ({1'b0, prevCost} + thrWide);
  assign costDown = ({1'b0, curCost} + thrWide) < {1'b0, prevCost};

  assign loBound = (cfgMin < PT_BOT) ? PT_BOT : cfgMin;
  assign hiBound = (cfgMax > PT_TOP) ? PT_TOP : cfgMax;
  assign canUp   = partPoint < hiBound;
  assign canDn   = partPoint > loBound;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winCost <= '0;
      missCnt <= '0;
    end else if (counted) begin
      if (winDone) begin
        winCost <= '0;
        missCnt <= '0;
      end else begin
        winCost <= curCost;
        missCnt <= missCnt + WC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevCost <= '0;
    else if (ctl.closeWin) prevCost <= curCost;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) partPoint <= PT_W'(INIT_POINT);
    else if (ctl.stepUp) partPoint <= partPoint + PT_W'(1);
    else if (ctl.stepDn) partPoint <= partPoint - PT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) firstLevelCount <= '0;
    else if (firstLevel && firstLevelCount != CNT_MAX)
      firstLevelCount <= firstLevelCount + CNT_W'(1);
  end

endmodule

// File: rtl/pptune_control.sv
module pptune_control
  import pptune_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     winDone,
  input  logic     costUp,
  input  logic     costDown,
  input  logic     canUp,
  input  logic     canDn,
  output tuneCtl_t ctl,
  output logic     updateStrobe
);

  logic havePrev;
  logic dirUp;
  logic nextDir;
  logic wantMove;

  always_comb begin
    nextDir  = dirUp;
    wantMove = 1'b0;
    if (!havePrev) begin
      wantMove = 1'b1;
    end else if (costUp) begin
      nextDir  = !dirUp;
      wantMove = 1'b1;
    end else if (costDown) begin
      wantMove = 1'b1;
    end
  end

  always_comb begin
    ctl.closeWin = winDone;
    ctl.stepUp   = winDone && wantMove && nextDir && canUp;
    ctl.stepDn   = winDone && wantMove && !nextDir && canDn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      havePrev     <= 1'b0;
      dirUp        <= 1'b1;
      updateStrobe <= 1'b0;
    end else begin
      updateStrobe <= winDone;
      if (winDone) begin
        havePrev <= 1'b1;
        dirUp    <= nextDir;
      end
    end
  end

endmodule

// File: rtl/partition_tuner.sv
module partition_tuner
  import pptune_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 64,
  parameter int unsigned WIN_MISSES = 256,
  parameter int unsigned COST_W     = 20,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned SH_W       = 4,
  parameter int unsigned INIT_POINT = 8,
  localparam int unsigned PT_W      = $clog2(NUM_SLOTS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             missValid,
  input  logic [2:0]       missClass,
  input  logic [PT_W-1:0]  cfgMin,
  input  logic [PT_W-1:0]  cfgMax,
  input  logic [SH_W-1:0]  cfgShift,
  output logic [PT_W-1:0]  partPoint,
  output logic [PT_W:0]    upperSlots,
  output logic             updateStrobe,
  output logic [CNT_W-1:0] firstLevelCount
);

  tuneCtl_t ctl;
  logic winDone, costUp, costDown, canUp, canDn;

  pptune_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .WIN_MISSES(WIN_MISSES), .COST_W(COST_W),
    .CNT_W(CNT_W), .SH_W(SH_W), .INIT_POINT(INIT_POINT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .missValid(missValid), .missClass(missClass),
    .cfgMin(cfgMin), .cfgMax(cfgMax), .cfgShift(cfgShift), .ctl(ctl),
    .winDone(winDone), .costUp(costUp), .costDown(costDown),
    .canUp(canUp), .canDn(canDn), .partPoint(partPoint),
    .firstLevelCount(firstLevelCount)
  );

  pptune_control u_ctl (
    .clk(clk), .rst_n(rst_n), .winDone(winDone), .costUp(costUp),
    .costDown(costDown), .canUp(canUp), .canDn(canDn), .ctl(ctl),
    .updateStrobe(updateStrobe)
  );

  assign upperSlots = (PT_W+1)'(NUM_SLOTS) - {1'b0, partPoint};

endmodule

// File: rtl/pptune_chk.sv
module pptune_chk #(
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned CNT_W     = 32,
  localparam int unsigned PT_W     = $clog2(NUM_SLOTS)
)(
  input logic             clk,
  input logic             rst_n,
  input logic [PT_W-1:0]  partPoint,
  input logic             updateStrobe,
  input logic [CNT_W-1:0] firstLevelCount
);

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else started <= 1'b1;
  end

  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updateStrobe |=> !updateStrobe);

  // R7
  point_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (partPoint >= PT_W'(1)) && (partPoint <= PT_W'(NUM_SLOTS - 1)));

  // R6
  move_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$stable(partPoint)) |-> updateStrobe);

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((partPoint == $past(partPoint)) ||
                 (partPoint == $past(partPoint) + PT_W'(1)) ||
                 (partPoint == $past(partPoint) - PT_W'(1))));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((firstLevelCount == $past(firstLevelCount)) ||
                 (firstLevelCount == $past(firstLevelCount) + CNT_W'(1))));

endmodule

bind partition_tuner pptune_chk #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .partPoint(partPoint),
  .updateStrobe(updateStrobe), .firstLevelCount(firstLevelCount)
);

// File: tb/partition_tuner_tb.sv
`timescale 1ns/1ps
module partition_tuner_tb;

  localparam int NSL  = 64;
  localparam int WIN  = 12;
  localparam int CW   = 12;
  localparam int CNTW = 4;
  localparam int INIT = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       missValid = 1'b0;
  logic [2:0] missClass = '0;
  logic [5:0] cfgMin = 6'd1;
  logic [5:0] cfgMax = 6'd63;
  logic [3:0] cfgShift = 4'd3;
  logic [5:0] partPoint;
  logic [6:0] upperSlots;
  logic       updateStrobe;
  logic [CNTW-1:0] firstLevelCount;

  always #2.5 clk = ~clk;

  partition_tuner #(.NUM_SLOTS(NSL), .WIN_MISSES(WIN), .COST_W(CW),
    .CNT_W(CNTW), .SH_W(4), .INIT_POINT(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .missValid(missValid), .missClass(missClass),
    .cfgMin(cfgMin), .cfgMax(cfgMax), .cfgShift(cfgShift),
    .partPoint(partPoint), .upperSlots(upperSlots),
    .updateStrobe(updateStrobe), .firstLevelCount(firstLevelCount));

  int total = 0;
  int bad = 0;
  bit done = 0;

  int mPoint, mPrev, mCount;
  bit mDir, mHave;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int wt(input int c);
    case (c)
      0: return 20;
      1: return 294;
      2: return 407;
      3: return 286;
      4: return 405;
      default: return 0;
    endcase
  endfunction

  // One miss: drive at a falling edge, sample at the next falling edge.
  task automatic sendMiss(input int c, input bit last);
    @(negedge clk);
    missValid = 1'b1;
    missClass = 3'(c);
    @(negedge clk);
    missValid = 1'b0;
    if (c <= 1 && mCount < (1 << CNTW) - 1) mCount++;
    check(updateStrobe == last, "R2", int'(updateStrobe), int'(last));
    if (c >= 5) begin
      // R1: ignored code leaves strobe and counter untouched
      check(firstLevelCount == CNTW'(mCount), "R1", int'(firstLevelCount), mCount);
    end
  endtask

  // Window: n misses of class c, the rest class 0, with an ignored code inserted.
  task automatic runWindow(input int c, input int n);
    int cost = 0;
    int thr, lo, hi;
    bit move = 0;
    string tag;
    for (int i = 0; i < WIN; i++) begin
      int cls = (i < n) ? c : 0;
      if (i == 5) sendMiss(5 + (c % 3), 1'b0);
      cost = cost + wt(cls);
      if (cost > CMAX) cost = CMAX;
      sendMiss(cls, i == WIN - 1);
    end
    lo = (cfgMin < 1) ? 1 : int'(cfgMin);
    hi = int'(cfgMax);
    if (!mHave) begin
      move = 1; tag = "R3";
    end else begin
      thr = mPrev >> cfgShift;
      if (cost > mPrev + thr) begin mDir = !mDir; move = 1; tag = "R4"; end
      else if (cost + thr < mPrev) begin move = 1; tag = "R5"; end
      else tag = "R6";
    end
    if (move) begin
      if (mDir && mPoint < hi) mPoint++;
      else if (!mDir && mPoint > lo) mPoint--;
      else tag = "R7";
    end
    if (cost == CMAX && mHave && mPrev == CMAX) tag = "R8";
    mPrev = cost;
    mHave = 1;
    check(partPoint == 6'(mPoint), tag, int'(partPoint), mPoint);
    check(upperSlots == 7'(NSL - mPoint), "R9", int'(upperSlots), NSL - mPoint);
    check(firstLevelCount == CNTW'(mCount), "R10", int'(firstLevelCount), mCount);
    @(negedge clk);
    check(updateStrobe == 1'b0, "R2", int'(updateStrobe), 0);
  endtask

  initial begin
    mPoint = INIT; mPrev = 0; mCount = 0; mDir = 1; mHave = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(partPoint == 6'(INIT), "R11", int'(partPoint), INIT);
    check(updateStrobe == 1'b0, "R11", int'(updateStrobe), 0);
    check(firstLevelCount == '0, "R11", int'(firstLevelCount), 0);
    rst_n = 1'b1;

    // Mixed-class sweep under several thresholds
    for (int s = 0; s < 4; s++) begin
      cfgShift = 4'(s + 1);
      for (int r = 0; r < 20; r++) runWindow((r * 3 + s) % 5, (r * 7 + s) % 13);
    end

    // R8: saturated windows compare equal and hold
    runWindow(2, 12);
    runWindow(2, 12);
    runWindow(4, 12);

    // R7: pin the range to the current point, then alternate costs
    cfgMin = 6'(mPoint);
    cfgMax = 6'(mPoint);
    for (int r = 0; r < 6; r++) runWindow((r % 2) ? 2 : 0, (r % 2) ? 12 : 0);

    // R7: lower bound written as 0 behaves as 1; narrow upper bound
    cfgMin = 6'd0;
    cfgMax = 6'(mPoint + 2);
    cfgShift = 4'd0;
    for (int r = 0; r < 40; r++) runWindow(r % 5, (r * 5) % 13);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule